// File: doc/BRIEF.md
# Instruction Fetch Unit

This block produces the address of the instruction being executed and the 9-bit machine word stored there. A program counter register advances by one word per cycle, because every 9-bit instruction takes exactly one address. A start request reloads the counter from a supplied start address. A branch flag, qualified by a taken flag, redirects the counter to a branch target.

A build-time parameter selects how the target is read. It is either an absolute word address or a signed two's-complement distance added to the current counter. The instruction store is a read-only array filled at elaboration from a fixed formula. It is read combinationally, so the word always matches the counter in the same cycle. A sticky completion flag tells the surrounding core that the program has reached a configured halt address.

Top module: `fetch_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, the counter becomes 0 after that edge.
- R2: When `start_i` is high at an edge (and `rst` is low), the counter becomes `start_addr_i`, regardless of `branch_i`, `taken_i` and `target_i`.
- R3: With `start_i` and `branch_i` low, the counter becomes its current value plus 1, and `taken_i` has no effect.
- R4: With `branch_i` high and `taken_i` low (no start), the counter becomes its current value plus 1.
- R5: With `REL_TARGET` = 0, `branch_i` and `taken_i` both high (no start), the counter becomes `target_i`.
- R6: With `REL_TARGET` = 1, a taken branch sets the counter to the current value plus `target_i`, read as a PC_W-bit two's-complement number, modulo 2^PC_W.
- R7: An increment from the highest address (2^PC_W - 1) wraps to 0.
- R8: `instr_o` equals the stored word at `pc_o` in the same cycle. The word at address a is ((a*37 + 5) XOR (a >> 3)) truncated to its low INSTR_W bits.
- R9: `done_o` is high in any cycle where `pc_o` equals `HALT_ADDR`, and it stays high in every later cycle until an edge with `start_i` or `rst` high. After that edge it equals (`pc_o` == `HALT_ADDR`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Load the start address at this edge |
| start_addr_i | input | PC_W | Address loaded by a start request |
| branch_i | input | 1 | The current instruction is a branch |
| taken_i | input | 1 | The branch resolved as taken |
| target_i | input | PC_W | Absolute target, or signed distance in relative mode |
| pc_o | output | PC_W | Current program counter |
| instr_o | output | INSTR_W | Stored word at the current counter |
| done_o | output | 1 | Halt address reached since the last start |

## Verification
The counter responds one clock edge after the controls that select it are presented. The instruction word and the completion flag follow the counter combinationally, in the same cycle. The bench drives the controls on the falling edge and lets one rising edge pass. It then compares counter, word and flag on the next falling edge against a model that has been advanced by exactly that one edge. Two instances, one in each target mode, receive the same stimulus, so absolute and relative branches are checked side by side in every cycle.

// File: rtl/fetch_pkg.sv
package fetch_pkg;

  typedef enum logic [1:0] {
    SEL_SEQ   = 2'd0,
    SEL_START = 2'd1,
    SEL_JUMP  = 2'd2
  } next_sel_e;

  // Stored word formula; callers truncate to the word width.
  function automatic logic [31:0] rom_word(input int unsigned a);
    logic [31:0] prod;
    prod = 32'(a) * 32'd37 + 32'd5;
    return prod ^ (32'(a) >> 3);
  endfunction

  // Sign-extend a two's-complement distance by one bit.
  function automatic logic [32:0] sext1(input logic [31:0] v, input int unsigned w);
    logic [32:0] r;
    r = {1'b0, v};
    r[w] = v[w-1];
    return r;
  endfunction

endpackage

// File: rtl/fetch_next_pc.sv
module fetch_next_pc
  import fetch_pkg::*;
#(
  parameter int PC_W       = 10,
  parameter bit REL_TARGET = 1'b0
) (
  input  logic [PC_W-1:0] pc_i,
  input  logic            start_i,
  input  logic [PC_W-1:0] start_addr_i,
  input  logic            branch_i,
  input  logic            taken_i,
  input  logic [PC_W-1:0] target_i,
  output logic [PC_W-1:0] nxt_o,
  output next_sel_e       sel_o
);

  logic [PC_W-1:0] seq_addr;
  logic [PC_W-1:0] jump_addr;

  assign seq_addr = pc_i + PC_W'(1);

  generate
    if (REL_TARGET) begin : g_rel
      logic [PC_W:0] pc_ext;
      logic [PC_W:0] off_ext;
      logic [PC_W:0] sum;
      assign pc_ext  = {1'b0, pc_i};
      assign off_ext = {target_i[PC_W-1], target_i};
      assign sum     = pc_ext + off_ext;
      assign jump_addr = sum[PC_W-1:0];
    end else begin : g_abs
      assign jump_addr = target_i;
    end
  endgenerate

  always_comb begin
    if (start_i)                   sel_o = SEL_START;
    else if (branch_i && taken_i)  sel_o = SEL_JUMP;
    else                           sel_o = SEL_SEQ;
  end

  always_comb begin
    case (sel_o)
      SEL_START: nxt_o = start_addr_i;
      SEL_JUMP:  nxt_o = jump_addr;
      default:   nxt_o = seq_addr;
    endcase
  end

endmodule

// File: rtl/fetch_rom.sv
module fetch_rom
  import fetch_pkg::*;
#(
  parameter int PC_W    = 10,
  parameter int INSTR_W = 9
) (
  input  logic [PC_W-1:0]    addr_i,
  output logic [INSTR_W-1:0] data_o
);

  localparam int DEPTH = 1 << PC_W;

  logic [INSTR_W-1:0] mem [DEPTH];

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_word
      assign mem[i] = INSTR_W'(rom_word(i));
    end
  endgenerate

  assign data_o = mem[addr_i];

endmodule

// File: rtl/fetch_halt.sv
module fetch_halt #(
  parameter int PC_W = 10,
  parameter logic [PC_W-1:0] HALT_ADDR = '1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_i,
  input  logic [PC_W-1:0] pc_i,
  output logic            done_o
);

  logic at_halt;
  logic done_q;

  assign at_halt = (pc_i == HALT_ADDR);

  always_ff @(posedge clk) begin
    if (rst || start_i) done_q <= 1'b0;
    else if (at_halt)   done_q <= 1'b1;
  end

  assign done_o = done_q | at_halt;

  // R9
  done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && !start_i) |=> done_o);

  // R9
  halt_seen_chk: assert property (@(posedge clk) disable iff (rst)
    at_halt |-> done_o);

endmodule

// File: rtl/fetch_unit.sv
module fetch_unit
  import fetch_pkg::*;
#(
  parameter int PC_W       = 10,
  parameter int INSTR_W    = 9,
  parameter bit REL_TARGET = 1'b0,
  parameter logic [PC_W-1:0] HALT_ADDR = 10'd300
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic [PC_W-1:0]    start_addr_i,
  input  logic               branch_i,
  input  logic               taken_i,
  input  logic [PC_W-1:0]    target_i,
  output logic [PC_W-1:0]    pc_o,
  output logic [INSTR_W-1:0] instr_o,
  output logic               done_o
);

  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] pc_nxt;
  next_sel_e       sel;

  // Named events for the checks below.
  logic ev_load_start;
  logic ev_jump;
  logic ev_seq;

  fetch_next_pc #(.PC_W(PC_W), .REL_TARGET(REL_TARGET)) u_next (
    .pc_i        (pc_q),
    .start_i     (start_i),
    .start_addr_i(start_addr_i),
    .branch_i    (branch_i),
    .taken_i     (taken_i),
    .target_i    (target_i),
    .nxt_o       (pc_nxt),
    .sel_o       (sel)
  );

  assign ev_load_start = (sel == SEL_START);
  assign ev_jump       = (sel == SEL_JUMP);
  assign ev_seq        = (sel == SEL_SEQ);

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_nxt;
  end

  assign pc_o = pc_q;

  fetch_rom #(.PC_W(PC_W), .INSTR_W(INSTR_W)) u_rom (
    .addr_i(pc_q),
    .data_o(instr_o)
  );

  fetch_halt #(.PC_W(PC_W), .HALT_ADDR(HALT_ADDR)) u_halt (
    .clk    (clk),
    .rst    (rst),
    .start_i(start_i),
    .pc_i   (pc_q),
    .done_o (done_o)
  );

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (pc_o == '0));

  // R2
  start_load_chk: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (pc_o == $past(start_addr_i)));

  // R2
  start_wins_chk: assert property (@(posedge clk) disable iff (rst)
    start_i |-> (ev_load_start && !ev_jump && !ev_seq));

  // R3
  seq_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!start_i && !branch_i) |=> (pc_o == PC_W'($past(pc_o) + 1'b1)));

  // R4
  not_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (!start_i && branch_i && !taken_i) |=> (pc_o == PC_W'($past(pc_o) + 1'b1)));

  generate
    if (REL_TARGET) begin : g_rel_chk
      // R6
      rel_jump_chk: assert property (@(posedge clk) disable iff (rst)
        ev_jump |=> (pc_o == PC_W'($past(pc_o) + $past(target_i))));
    end else begin : g_abs_chk
      // R5
      abs_jump_chk: assert property (@(posedge clk) disable iff (rst)
        ev_jump |=> (pc_o == $past(target_i)));
    end
  endgenerate

  // R7
  wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (ev_seq && pc_o == '1) |=> (pc_o == '0));

endmodule

// File: tb/sim_fetch_unit.sv
module sim_fetch_unit;

  localparam int CLK_PERIOD = 10;
  localparam int PW = 10;
  localparam int IW = 9;
  localparam logic [PW-1:0] HALT = 10'd20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [PW-1:0] start_addr = '0;
  logic branch = 1'b0;
  logic taken = 1'b0;
  logic [PW-1:0] target = '0;

  logic [PW-1:0] pc0, pc1;
  logic [IW-1:0] ins0, ins1;
  logic done0, done1;

  int total = 0;
  int bad = 0;

  logic [PW-1:0] m_pc0, m_pc1;
  logic m_dq0, m_dq1;

  always #(CLK_PERIOD/2) clk = ~clk;

  fetch_unit #(.PC_W(PW), .INSTR_W(IW), .REL_TARGET(1'b0), .HALT_ADDR(HALT)) u0 (
    .clk(clk), .rst(rst), .start_i(start), .start_addr_i(start_addr),
    .branch_i(branch), .taken_i(taken), .target_i(target),
    .pc_o(pc0), .instr_o(ins0), .done_o(done0));

  fetch_unit #(.PC_W(PW), .INSTR_W(IW), .REL_TARGET(1'b1), .HALT_ADDR(HALT)) u1 (
    .clk(clk), .rst(rst), .start_i(start), .start_addr_i(start_addr),
    .branch_i(branch), .taken_i(taken), .target_i(target),
    .pc_o(pc1), .instr_o(ins1), .done_o(done1));

  function automatic logic [IW-1:0] exp_word(input logic [PW-1:0] a);
    int unsigned v;
    v = (int'(a) * 37 + 5) ^ (int'(a) / 8);
    return IW'(v % 512);
  endfunction

  function automatic logic [PW-1:0] exp_next(input logic [PW-1:0] pc, input logic s,
      input logic [PW-1:0] sa, input logic b, input logic t,
      input logic [PW-1:0] tg, input bit rel);
    int d;
    if (s) return sa;
    if (b && t) begin
      if (!rel) return tg;
      d = tg[PW-1] ? int'(tg) - 1024 : int'(tg);
      return PW'((int'(pc) + d + 1024) % 1024);
    end
    return PW'((int'(pc) + 1) % 1024);
  endfunction

  function automatic string tag_for(input logic [PW-1:0] pc, input logic s,
      input logic b, input logic t, input bit rel);
    if (s) return "R2";
    if (b && t) return rel ? "R6" : "R5";
    if (b) return "R4";
    if (pc == '1) return "R7";
    return "R3";
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string t0, input string t1);
    check(t0, "pc u0", int'(pc0), int'(m_pc0));
    check(t1, "pc u1", int'(pc1), int'(m_pc1));
    check("R8", "instr u0", int'(ins0), int'(exp_word(m_pc0)));
    check("R8", "instr u1", int'(ins1), int'(exp_word(m_pc1)));
    check("R9", "done u0", int'(done0), int'(m_dq0 | (m_pc0 == HALT)));
    check("R9", "done u1", int'(done1), int'(m_dq1 | (m_pc1 == HALT)));
  endtask

  // Called on a falling edge; returns on the next falling edge after checking.
  task automatic step(input logic s, input logic [PW-1:0] sa, input logic b,
      input logic t, input logic [PW-1:0] tg);
    string t0, t1;
    start = s; start_addr = sa; branch = b; taken = t; target = tg;
    t0 = tag_for(m_pc0, s, b, t, 1'b0);
    t1 = tag_for(m_pc1, s, b, t, 1'b1);
    @(posedge clk);
    m_dq0 = s ? 1'b0 : (m_dq0 | (m_pc0 == HALT));
    m_dq1 = s ? 1'b0 : (m_dq1 | (m_pc1 == HALT));
    m_pc0 = exp_next(m_pc0, s, sa, b, t, tg, 1'b0);
    m_pc1 = exp_next(m_pc1, s, sa, b, t, tg, 1'b1);
    @(negedge clk);
    check_all(t0, t1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = 32'd5171;
    void'($urandom(seed));
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    m_pc0 = '0; m_pc1 = '0; m_dq0 = 1'b0; m_dq1 = 1'b0;
    // R1 reset state
    check_all("R1", "R1");
    rst = 1'b0;

    // R3: taken alone is ignored
    repeat (3) step(1'b0, 10'd0, 1'b0, 1'b1, 10'd5);
    // R4: branch not taken
    step(1'b0, 10'd0, 1'b1, 1'b0, 10'd500);
    // R5/R6: taken branch
    step(1'b0, 10'd0, 1'b1, 1'b1, 10'd100);
    // R2: start beats a taken branch; then R7 wrap
    step(1'b1, 10'd1023, 1'b1, 1'b1, 10'd7);
    step(1'b0, 10'd0, 1'b0, 1'b0, 10'd0);
    // R6: negative distance 3 + (-5) wraps to 1022
    step(1'b1, 10'd3, 1'b0, 1'b0, 10'd0);
    step(1'b0, 10'd0, 1'b1, 1'b1, 10'h3FB);
    // R9: reach halt, stay done, clear on start
    step(1'b1, 10'd18, 1'b0, 1'b0, 10'd0);
    repeat (4) step(1'b0, 10'd0, 1'b0, 1'b1, 10'd0);
    step(1'b0, 10'd0, 1'b1, 1'b1, 10'd700);
    step(1'b1, 10'd5, 1'b0, 1'b0, 10'd0);
    // R1 mid-run reset
    rst = 1'b1;
    @(posedge clk);
    m_pc0 = '0; m_pc1 = '0; m_dq0 = 1'b0; m_dq1 = 1'b0;
    @(negedge clk);
    check_all("R1", "R1");
    rst = 1'b0;

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      logic s, b, t;
      s = ($urandom % 20) == 0;
      b = ($urandom % 4) == 0;
      t = ($urandom % 2) == 0;
      step(s, PW'($urandom % 64), b, t, PW'($urandom));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule